// File: doc/BRIEF.md
# Pairwise-Product Beamforming Combiner

This block is a streaming combiner for a receive array. It takes one signed sample per channel on a wide parallel bus whenever an input strobe is high. It delays each channel by its own programmable number of samples and produces two results for every accepted sample set. The first result is the plain sum of the delayed samples, as a delay-and-sum beamformer would give. The second is the sum of the products of every distinct pair of delayed samples.

The pair sum does not use one multiplier per channel pair. Each channel squares its own delayed sample. The channel sum is squared once. The pair sum is then half of the squared sum minus the sum of squares. Only the two final reductions combine channels, so the number of multipliers grows linearly with the channel count.

Delays come from per-channel fields on a static input bus and are read each time a sample set is accepted. A fixed four-stage pipeline follows the delay lines. A valid strobe travels through that pipeline next to the data.

Top module: `pair_beam_combiner`

## Requirements
- R1: While reset is held, outValid, dasOut and pairOut are all zero.
- R2: Channel c takes its sample from inSamples[c*16 +: 16] (signed 16-bit two's complement) and its delay d (0 to 31) from chDelays[c*5 +: 5]. That channel contributes the sample accepted d strobes before the current one, where d = 0 means the current sample. History from before reset counts as zero.
- R3: dasOut (signed 19-bit) equals the exact sum of the eight delayed samples and never overflows.
- R4: pairOut (signed 40-bit) equals the exact sum of x[i]*x[j] over all channel pairs i<j of the delayed samples. This holds for extreme inputs, including every channel at -32768.
- R5: A sample set accepted at the rising edge k where inValid is high gives outValid high for one cycle after edge k+4, with both results for that set. Back-to-back sets give back-to-back results.
- R6: dasOut and pairOut keep their values in every cycle in which outValid is low.
- R7: Delay lines advance only on accepted samples, so idle cycles do not age the history. A change to chDelays applies from the next accepted sample set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | The sample set on inSamples is accepted at this edge |
| inSamples | input | 128 | Eight signed 16-bit samples, channel c at bits c*16 +: 16 |
| chDelays | input | 40 | Eight 5-bit delays in samples, channel c at bits c*5 +: 5 |
| outValid | output | 1 | One-cycle strobe marking new results |
| dasOut | output | 19 | Signed sum of the delayed samples |
| pairOut | output | 40 | Signed sum of all distinct pair products |

## Verification
The hardest case to reach from the ports is a channel reading deep history while the input strobe has gaps and the delays change in between. In that case an aging error or a wrong tap index looks like a plausible value. The stimulus gives every sample a value that encodes its channel and its sequence number. It spreads the delays over 0 to 31, inserts random idle gaps and reprograms the delays between sets. A brute-force model of the history and of the double loop over pairs then predicts each result exactly. Sets of extreme values, with all channels at the most negative or most positive code, push the squared sum to its full width.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  // Stage enables passed from the control sequencer into the datapath.
  typedef struct packed {
    logic capture;   // accept a new sample set into the delay lines and tap registers
    logic sqEn;      // tap registers hold a set: form per-channel squares
    logic sumEn;     // squares are ready: reduce over channels
    logic mulEn;     // sums are ready: square the channel sum
    logic finEn;     // square of sum is ready: subtract and halve
  } pbc_strobe_t;

endpackage

// File: rtl/pbc_delay_line.sv
module pbc_delay_line #(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_DELAY = 31,
  parameter int DELAY_W   = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       shiftEn,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic        [DELAY_W-1:0]  delaySel,
  output logic signed [SAMPLE_W-1:0] tapOut
);

  // hist[i] holds the sample accepted i+1 strobes ago
  logic signed [SAMPLE_W-1:0] hist [MAX_DELAY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_DELAY; i++) hist[i] <= '0;
    end else if (shiftEn) begin
      hist[0] <= sampleIn;
      for (int i = 1; i < MAX_DELAY; i++) hist[i] <= hist[i-1];
    end
  end

  // Zero delay passes the incoming sample; larger codes clamp to the oldest entry
  always_comb begin
    tapOut = sampleIn;
    for (int i = 0; i < MAX_DELAY; i++) begin
      if (int'(delaySel) == i + 1) tapOut = hist[i];
    end
    if (int'(delaySel) > MAX_DELAY) tapOut = hist[MAX_DELAY-1];
  end

endmodule

// File: rtl/pbc_ctrl.sv
module pbc_ctrl
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output pbc_strobe_t strobe,
  output logic        outValid
);

  localparam int STAGES = 5;

  // validPipe[0] marks a set in the tap registers, validPipe[4] marks finished results
  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.sqEn    = validPipe[0];
    strobe.sumEn   = validPipe[1];
    strobe.mulEn   = validPipe[2];
    strobe.finEn   = validPipe[3];
  end

  assign outValid = validPipe[STAGES-1];

endmodule

// File: rtl/pbc_datapath.sv
module pbc_datapath
  import pbc_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int SAMPLE_W  = 16,
  parameter int MAX_DELAY = 31,
  parameter int DELAY_W   = 5,
  parameter int SUM_W     = 19,
  parameter int RES_W     = 40
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  pbc_strobe_t                      strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0]       inSamples,
  input  logic [NUM_CH*DELAY_W-1:0]        chDelays,
  output logic signed [SUM_W-1:0]          dasOut,
  output logic signed [RES_W-1:0]          pairOut
);

  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SQ_W    = 2 * SAMPLE_W;
  localparam int SQSUM_W = SQ_W + CH_BITS;

  logic signed [SAMPLE_W-1:0] tapComb  [NUM_CH];
  logic signed [SAMPLE_W-1:0] tapReg   [NUM_CH];
  logic signed [SAMPLE_W-1:0] sampleS1 [NUM_CH];
  logic signed [SQ_W-1:0]     squareS1 [NUM_CH];

  // Per-channel section: delay, tap register and self-square, no cross-channel terms
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic signed [SQ_W-1:0] tapWide;

    pbc_delay_line #(
      .SAMPLE_W (SAMPLE_W),
      .MAX_DELAY(MAX_DELAY),
      .DELAY_W  (DELAY_W)
    ) u_delayLine (
      .clk     (clk),
      .rstN    (rstN),
      .shiftEn (strobe.capture),
      .sampleIn(inSamples[c*SAMPLE_W +: SAMPLE_W]),
      .delaySel(chDelays[c*DELAY_W +: DELAY_W]),
      .tapOut  (tapComb[c])
    );

    assign tapWide = SQ_W'(tapReg[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tapReg[c]   <= '0;
        sampleS1[c] <= '0;
        squareS1[c] <= '0;
      end else begin
        if (strobe.capture) tapReg[c] <= tapComb[c];
        if (strobe.sqEn) begin
          sampleS1[c] <= tapReg[c];
          squareS1[c] <= tapWide * tapWide;
        end
      end
    end
  end

  // Two channel reductions: one over samples, one over squares
  logic signed [SUM_W-1:0]   sumAcc;
  logic signed [SQSUM_W-1:0] sqAcc;

  always_comb begin
    sumAcc = '0;
    sqAcc  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      sumAcc = sumAcc + SUM_W'(sampleS1[c]);
      sqAcc  = sqAcc + SQSUM_W'(squareS1[c]);
    end
  end

  logic signed [SUM_W-1:0]   sumS2;
  logic signed [SQSUM_W-1:0] sqSumS2;
  logic signed [SUM_W-1:0]   sumS3;
  logic signed [SQSUM_W-1:0] sqSumS3;
  logic signed [RES_W-1:0]   sumSquaredS3;
  logic signed [RES_W-1:0]   sumWide;
  logic signed [RES_W-1:0]   pairDiff;

  assign sumWide  = RES_W'(sumS2);
  assign pairDiff = sumSquaredS3 - RES_W'(sqSumS3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumS2        <= '0;
      sqSumS2      <= '0;
      sumS3        <= '0;
      sqSumS3      <= '0;
      sumSquaredS3 <= '0;
      dasOut       <= '0;
      pairOut      <= '0;
    end else begin
      if (strobe.sumEn) begin
        sumS2   <= sumAcc;
        sqSumS2 <= sqAcc;
      end
      if (strobe.mulEn) begin
        sumS3        <= sumS2;
        sqSumS3      <= sqSumS2;
        sumSquaredS3 <= sumWide * sumWide;
      end
      if (strobe.finEn) begin
        dasOut  <= sumS3;
        pairOut <= pairDiff >>> 1;   // difference is always even
      end
    end
  end

endmodule

// File: rtl/pair_beam_combiner.sv
module pair_beam_combiner
  import pbc_pkg::*;
#(
  parameter int  NUM_CH    = 8,
  parameter int  SAMPLE_W  = 16,
  parameter int  MAX_DELAY = 31,
  localparam int DELAY_W   = $clog2(MAX_DELAY + 1),
  localparam int CH_BITS   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SUM_W     = SAMPLE_W + CH_BITS,
  localparam int RES_W     = 2 * SUM_W + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [NUM_CH*SAMPLE_W-1:0]  inSamples,
  input  logic [NUM_CH*DELAY_W-1:0]   chDelays,
  output logic                        outValid,
  output logic signed [SUM_W-1:0]     dasOut,
  output logic signed [RES_W-1:0]     pairOut
);

  pbc_strobe_t strobe;

  pbc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  pbc_datapath #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .MAX_DELAY(MAX_DELAY),
    .DELAY_W  (DELAY_W),
    .SUM_W    (SUM_W),
    .RES_W    (RES_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSamples(inSamples),
    .chDelays (chDelays),
    .dasOut   (dasOut),
    .pairOut  (pairOut)
  );

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 19,
  parameter int RES_W    = 40
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    outValid,
  input logic signed [SUM_W-1:0] dasOut,
  input logic signed [RES_W-1:0] pairOut
);

  localparam longint HALF_RANGE = longint'(1) <<< (SAMPLE_W - 1);
  localparam longint DAS_MIN    = -(longint'(NUM_CH) * HALF_RANGE);
  localparam longint DAS_MAX    = longint'(NUM_CH) * (HALF_RANGE - 1);
  localparam longint SQ_MAX     = HALF_RANGE * HALF_RANGE;
  localparam longint PAIR_MAX   = (longint'(NUM_CH) * longint'(NUM_CH - 1) / 2) * SQ_MAX;
  localparam longint PAIR_MIN   = -((longint'(NUM_CH) * SQ_MAX) / 2);

  logic [2:0] sinceRst;
  logic       rstSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  always_ff @(posedge clk) rstSeen <= !rstN;

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rstN && rstSeen) begin
      p_reset_clear_r1: assert (!outValid && dasOut == '0 && pairOut == '0)
        else $error("outputs not cleared in reset");
    end
  end

  // R5: the result strobe trails the input strobe by the fixed pipeline
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6) |-> (outValid == $past(inValid, 5)));

  // R6: results hold when no strobe is issued
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd2 && !outValid) |-> ($stable(dasOut) && $stable(pairOut)));

  // R3: the plain sum stays in the range eight samples can reach
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (longint'(dasOut) >= DAS_MIN && longint'(dasOut) <= DAS_MAX));

  // R4: the pair sum stays between its algebraic bounds
  p_pair_bounds_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (longint'(pairOut) >= PAIR_MIN && longint'(pairOut) <= PAIR_MAX));

endmodule

bind pair_beam_combiner pbc_checker #(
  .NUM_CH  (NUM_CH),
  .SAMPLE_W(SAMPLE_W),
  .SUM_W   (SUM_W),
  .RES_W   (RES_W)
) u_pbcChecker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .dasOut  (dasOut),
  .pairOut (pairOut)
);

// File: tb/tb_pair_beam_combiner.sv
module tb_pair_beam_combiner;

  localparam int N  = 8;
  localparam int SW = 16;
  localparam int DW = 5;
  localparam int HD = 32;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    inValid = 1'b0;
  logic [N*SW-1:0]         inSamples = '0;
  logic [N*DW-1:0]         chDelays = '0;
  logic                    outValid;
  logic signed [18:0]      dasOut;
  logic signed [39:0]      pairOut;

  pair_beam_combiner dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSamples(inSamples),
    .chDelays (chDelays),
    .outValid (outValid),
    .dasOut   (dasOut),
    .pairOut  (pairOut)
  );

  always #10 clk = ~clk;   // 50 MHz

  int     checks = 0;
  int     failures = 0;
  bit     done = 1'b0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  longint mHist [N][HD];
  int     dly [N];
  longint qDue [$];
  longint qDas [$];
  longint qPair [$];
  string  qTag [$];
  longint lastDas = 0;
  longint lastPair = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (qDue.size() > 0 && qDue[0] == cyc) begin
        check(outValid == 1'b1, "R5", "outValid at due cycle", longint'(outValid), 1);
        check(longint'(dasOut) == qDas[0], {qTag[0], "/R3"}, "dasOut", longint'(dasOut), qDas[0]);
        check(longint'(pairOut) == qPair[0], {qTag[0], "/R4"}, "pairOut", longint'(pairOut), qPair[0]);
        void'(qDue.pop_front());
        void'(qDas.pop_front());
        void'(qPair.pop_front());
        void'(qTag.pop_front());
      end else if (outValid) begin
        check(1'b0, "R5", "unexpected outValid", 1, 0);
      end else begin
        check(longint'(dasOut) == lastDas && longint'(pairOut) == lastPair,
              "R6", "held dasOut", longint'(dasOut), lastDas);
      end
      lastDas  = longint'(dasOut);
      lastPair = longint'(pairOut);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic setDelays(input int d [N]);
    @(negedge clk);
    inValid = 1'b0;
    for (int c = 0; c < N; c++) begin
      dly[c] = d[c];
      chDelays[c*DW +: DW] = DW'(d[c]);
    end
  endtask

  // Drive one sample set and queue its predicted results
  task automatic sendSet(input longint s [N], input string tag);
    longint v [N];
    longint das;
    longint pr;
    @(negedge clk);
    das = 0;
    pr  = 0;
    for (int c = 0; c < N; c++) begin
      v[c] = (dly[c] == 0) ? s[c] : mHist[c][dly[c]-1];
      das += v[c];
      inSamples[c*SW +: SW] = SW'(s[c]);
    end
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        pr += v[i] * v[j];
    inValid = 1'b1;
    qDue.push_back(cyc + 5);
    qDas.push_back(das);
    qPair.push_back(pr);
    qTag.push_back(tag);
    for (int c = 0; c < N; c++) begin
      for (int k = HD - 1; k > 0; k--) mHist[c][k] = mHist[c][k-1];
      mHist[c][0] = s[c];
    end
  endtask

  function automatic longint rndSample();
    logic [15:0] r;
    r = 16'($urandom);
    return longint'($signed(r));
  endfunction

  task automatic testReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", longint'(outValid), 0);
    check(dasOut == '0, "R1", "dasOut in reset", longint'(dasOut), 0);
    check(pairOut == '0, "R1", "pairOut in reset", longint'(pairOut), 0);
    rstN = 1'b1;
    idle(3);
    check(outValid == 1'b0, "R1", "outValid after release", longint'(outValid), 0);
  endtask

  task automatic testZeroDelay();
    int     d [N];
    longint s [N];
    for (int c = 0; c < N; c++) d[c] = 0;
    setDelays(d);
    for (int k = 0; k < 12; k++) begin
      for (int c = 0; c < N; c++) s[c] = rndSample();
      sendSet(s, "R5_backtoback");
    end
    idle(8);
  endtask

  task automatic testExtremes();
    longint s [N];
    for (int c = 0; c < N; c++) s[c] = -32768;
    sendSet(s, "R4_allneg");
    for (int c = 0; c < N; c++) s[c] = 32767;
    sendSet(s, "R4_allpos");
    for (int c = 0; c < N; c++) s[c] = (c % 2 == 0) ? 32767 : -32768;
    sendSet(s, "R4_alternate");
    for (int c = 0; c < N; c++) s[c] = (c == 3) ? -32768 : 0;
    sendSet(s, "R4_single");
    for (int c = 0; c < N; c++) s[c] = -1;
    sendSet(s, "R3_minusone");
    idle(8);
  endtask

  task automatic testDelays();
    int     d [N];
    longint s [N];
    for (int c = 0; c < N; c++) d[c] = (c == N - 1) ? 31 : c * 4 + (c % 3);
    setDelays(d);
    for (int k = 0; k < 40; k++) begin
      for (int c = 0; c < N; c++) s[c] = longint'(c * 1000 + k + 1) * ((k % 2 == 0) ? 1 : -1);
      sendSet(s, "R2_spread");
    end
    idle(8);
  endtask

  task automatic testIdleGaps();
    int     d [N];
    longint s [N];
    for (int c = 0; c < N; c++) d[c] = 1 + c * 3;
    setDelays(d);
    for (int k = 0; k < 30; k++) begin
      for (int c = 0; c < N; c++) s[c] = longint'(c * 500 - k * 7);
      sendSet(s, "R7_gaps");
      idle(int'($urandom_range(0, 6)));
    end
    idle(8);
  endtask

  task automatic testDelayChange();
    int     d [N];
    longint s [N];
    for (int k = 0; k < 24; k++) begin
      if (k % 4 == 0) begin
        for (int c = 0; c < N; c++) d[c] = int'($urandom_range(0, 31));
        setDelays(d);
      end
      for (int c = 0; c < N; c++) s[c] = rndSample();
      sendSet(s, "R7_reprogram");
    end
    idle(8);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      dly[c] = 0;
      for (int k = 0; k < HD; k++) mHist[c][k] = 0;
    end
    testReset();
    testZeroDelay();
    testExtremes();
    testDelays();
    testIdleGaps();
    testDelayChange();
    idle(4);
    done = 1'b1;
    check(qDue.size() == 0, "R5", "results outstanding", longint'(qDue.size()), 0);
    summary();
    $finish;
  end

endmodule